// File: doc/BRIEF.md
# Dual-Port Data/Program Word RAM

This block is a 544-word, 16-bit on-chip RAM that a processor core can reach twice in one clock: port A and port B each present an address, a space select (program or data), a write enable and write data, and each gets back its own read data. Both ports work on the same storage in the same cycle.

A mode input chooses how the storage is laid out. In all-data mode every word belongs to data space. In split mode the low 288 words stay in data space and the upper 256 words serve program fetches. The block decodes each request by space, address and the registered mode. It raises a per-port miss flag for a request that lands on no mapped word, and it settles two writes that target the same word in the same cycle.

The mode input is sampled on each clock edge. Contents survive a mode change, so data written in one layout can be read in the other.

Top module: `dual_access_ram`

## Requirements
- R1: While reset is asserted and in the first cycle after it, both read-data outputs and both miss flags are zero, and the registered mode is all-data.
- R2: In all-data mode (registered mode 0), a data-space request (space select 0) to address 0..543 reaches word `addr`. Its read data and miss flag appear one clock after the request. A write with enable 1 stores the data at that edge.
- R3: In all-data mode, every program-space request (space select 1) misses.
- R4: In split mode (registered mode 1), a data-space request to address 0..287 reaches word `addr`. A data-space request to address 288 or above misses.
- R5: In split mode, a program-space request to address 0..255 reaches word `288 + addr`. A program-space request to address 256 or above misses.
- R6: A request that misses returns read data of zero in the following cycle and leaves every stored word unchanged.
- R7: The two ports work independently in the same cycle, each on its own word.
- R8: When both ports write the same word in the same cycle, the word ends up holding port A's data.
- R9: When one port reads a word that is written in the same cycle, the reader gets the contents from before the write.
- R10: The mode input takes effect for requests presented after the next clock edge, and changing it leaves the stored contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| split_mode | input | 1 | 0 = all-data layout, 1 = data/program split layout |
| a_prog | input | 1 | Port A space select: 1 = program, 0 = data |
| a_addr | input | 10 | Port A address |
| a_we | input | 1 | Port A write enable |
| a_wdata | input | 16 | Port A write data |
| a_rdata | output | 16 | Port A read data, one clock after the request |
| a_miss | output | 1 | Port A unmapped-request flag, one clock after the request |
| b_prog | input | 1 | Port B space select: 1 = program, 0 = data |
| b_addr | input | 10 | Port B address |
| b_we | input | 1 | Port B write enable |
| b_wdata | input | 16 | Port B write data |
| b_rdata | output | 16 | Port B read data, one clock after the request |
| b_miss | output | 1 | Port B unmapped-request flag, one clock after the request |

## Verification
The bench targets the boundary addresses on both sides of each mapped range in both layouts: 287/288 for data in split mode, 255/256 for program, and 543/544 in all-data mode. An off-by-one decoder would hit where it should miss, or the reverse. A program write in all-data mode is followed by a read of the word it would alias to (288 + addr). A decoder that ignored the space select would corrupt that word. Same-word writes from both ports, and reads that overlap a same-cycle write, expose a wrong priority or a read path that forwards new data. A mode flip that cleared or remapped the array would return stale values when the same words are read through the other layout.

// File: rtl/dar_pkg.sv
package dar_pkg;
  typedef enum logic {
    MAP_ALL_DATA = 1'b0,
    MAP_SPLIT    = 1'b1
  } map_mode_e;

  localparam int unsigned DEF_DATA_W     = 16;
  localparam int unsigned DEF_DATA_WORDS = 288;
  localparam int unsigned DEF_PROG_WORDS = 256;
  localparam int unsigned DEF_ADDR_W     = 10;
  localparam int unsigned NUM_PORTS      = 2;
endpackage

// File: rtl/dar_port_decode.sv
module dar_port_decode
  import dar_pkg::*;
#(
  parameter int unsigned ADDR_W     = DEF_ADDR_W,
  parameter int unsigned DATA_WORDS = DEF_DATA_WORDS,
  parameter int unsigned PROG_WORDS = DEF_PROG_WORDS,
  localparam int unsigned TOTAL     = DATA_WORDS + PROG_WORDS,
  localparam int unsigned IDX_W     = $clog2(TOTAL)
) (
  input  map_mode_e          mode,
  input  logic               prog,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               we,
  output logic               hit,
  output logic               we_eff,
  output logic [IDX_W-1:0]   idx
);
  // Map a space/address pair onto an array word for a given layout.
  function automatic logic [IDX_W:0] map_word(input map_mode_e m, input logic p,
                                               input logic [ADDR_W-1:0] a);
    int unsigned av;
    logic        h;
    int unsigned w;
    av = int'(a);
    h  = 1'b0;
    w  = 0;
    if (m == MAP_SPLIT) begin
      if (p) begin
        h = (av < PROG_WORDS);
        w = DATA_WORDS + av;
      end else begin
        h = (av < DATA_WORDS);
        w = av;
      end
    end else begin
      h = !p && (av < TOTAL);
      w = av;
    end
    if (!h) w = 0;
    return {h, IDX_W'(w)};
  endfunction

  logic [IDX_W:0] mapped;
  assign mapped = map_word(mode, prog, addr);
  assign hit    = mapped[IDX_W];
  assign idx    = mapped[IDX_W-1:0];
  assign we_eff = we & hit;
endmodule

// File: rtl/dar_bank.sv
module dar_bank #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned TOTAL  = 544,
  localparam int unsigned IDX_W = $clog2(TOTAL)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_hit,
  input  logic              a_we,
  input  logic [IDX_W-1:0]  a_idx,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  input  logic              b_hit,
  input  logic              b_we,
  input  logic [IDX_W-1:0]  b_idx,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata
);
  logic [DATA_W-1:0] mem [TOTAL];

  // Named event: both ports write one word this cycle.
  logic wr_collide;
  logic b_store;
  assign wr_collide = a_we && b_we && (a_idx == b_idx);
  assign b_store    = b_we && !wr_collide;

  always_ff @(posedge clk) begin
    if (a_we)    mem[a_idx] <= a_wdata;
    if (b_store) mem[b_idx] <= b_wdata;
  end

  // Reads sample the array before this edge's writes land (old data).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_rdata <= '0;
      b_rdata <= '0;
    end else begin
      a_rdata <= a_hit ? mem[a_idx] : '0;
      b_rdata <= b_hit ? mem[b_idx] : '0;
    end
  end

  // R8: port A's data survives a same-word double write.
  a_r8_a_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_collide |=> mem[$past(a_idx)] == $past(a_wdata));

  // R9: a read overlapping a write of the same word returns the prior value.
  a_r9_read_old: assert property (@(posedge clk) disable iff (!rst_n)
    (b_hit && a_we && !b_we && a_idx == b_idx && mem[a_idx] != a_wdata)
      |=> b_rdata != mem[$past(a_idx)]);
endmodule

// File: rtl/dual_access_ram.sv
module dual_access_ram
  import dar_pkg::*;
#(
  parameter int unsigned DATA_W     = DEF_DATA_W,
  parameter int unsigned ADDR_W     = DEF_ADDR_W,
  parameter int unsigned DATA_WORDS = DEF_DATA_WORDS,
  parameter int unsigned PROG_WORDS = DEF_PROG_WORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              split_mode,
  input  logic              a_prog,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic              a_we,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  output logic              a_miss,
  input  logic              b_prog,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic              b_we,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata,
  output logic              b_miss
);
  localparam int unsigned TOTAL = DATA_WORDS + PROG_WORDS;
  localparam int unsigned IDX_W = $clog2(TOTAL);

  map_mode_e mode_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MAP_ALL_DATA;
    else        mode_q <= split_mode ? MAP_SPLIT : MAP_ALL_DATA;
  end

  logic              p_prog  [NUM_PORTS];
  logic [ADDR_W-1:0] p_addr  [NUM_PORTS];
  logic              p_we    [NUM_PORTS];
  logic              p_hit   [NUM_PORTS];
  logic              p_weff  [NUM_PORTS];
  logic [IDX_W-1:0]  p_idx   [NUM_PORTS];
  logic              miss_q  [NUM_PORTS];

  assign p_prog[0] = a_prog;  assign p_addr[0] = a_addr;  assign p_we[0] = a_we;
  assign p_prog[1] = b_prog;  assign p_addr[1] = b_addr;  assign p_we[1] = b_we;

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
    dar_port_decode #(
      .ADDR_W(ADDR_W), .DATA_WORDS(DATA_WORDS), .PROG_WORDS(PROG_WORDS)
    ) u_dec (
      .mode(mode_q), .prog(p_prog[g]), .addr(p_addr[g]), .we(p_we[g]),
      .hit(p_hit[g]), .we_eff(p_weff[g]), .idx(p_idx[g])
    );
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) miss_q[g] <= 1'b0;
      else        miss_q[g] <= !p_hit[g];
    end
  end

  dar_bank #(.DATA_W(DATA_W), .TOTAL(TOTAL)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .a_hit(p_hit[0]), .a_we(p_weff[0]), .a_idx(p_idx[0]), .a_wdata(a_wdata), .a_rdata(a_rdata),
    .b_hit(p_hit[1]), .b_we(p_weff[1]), .b_idx(p_idx[1]), .b_wdata(b_wdata), .b_rdata(b_rdata)
  );

  assign a_miss = miss_q[0];
  assign b_miss = miss_q[1];

  // R1: outputs are clear right after reset releases.
  a_r1_reset_clear: assert property (@(posedge clk)
    $rose(rst_n) |-> (a_rdata == '0 && b_rdata == '0 && !a_miss && !b_miss));
  // R6: a miss never returns data.
  a_r6_miss_zero_a: assert property (@(posedge clk) disable iff (!rst_n)
    a_miss |-> a_rdata == '0);
  a_r6_miss_zero_b: assert property (@(posedge clk) disable iff (!rst_n)
    b_miss |-> b_rdata == '0);
  // R3: program fetches miss in all-data layout.
  a_r3_prog_alldata: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MAP_ALL_DATA && a_prog) |=> a_miss);
  // R2: in-range data request hits in all-data layout.
  a_r2_alldata_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MAP_ALL_DATA && !b_prog && int'(b_addr) < TOTAL) |=> !b_miss);
  // R5: program addresses past the program region miss in split layout.
  a_r5_prog_range: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MAP_SPLIT && a_prog && int'(a_addr) >= PROG_WORDS) |=> a_miss);
  // R4: data addresses past the data region miss in split layout.
  a_r4_data_range: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MAP_SPLIT && !b_prog && int'(b_addr) >= DATA_WORDS) |=> b_miss);
endmodule

// File: tb/dual_access_ram_bench.sv
module dual_access_ram_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        split_mode = 1'b0;
  logic        a_prog = 0, b_prog = 0, a_we = 0, b_we = 0;
  logic [9:0]  a_addr = 0, b_addr = 0;
  logic [15:0] a_wdata = 0, b_wdata = 0;
  logic [15:0] a_rdata, b_rdata;
  logic        a_miss, b_miss;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  dual_access_ram u_dual_access_ram (
    .clk(clk), .rst_n(rst_n), .split_mode(split_mode),
    .a_prog(a_prog), .a_addr(a_addr), .a_we(a_we), .a_wdata(a_wdata),
    .a_rdata(a_rdata), .a_miss(a_miss),
    .b_prog(b_prog), .b_addr(b_addr), .b_we(b_we), .b_wdata(b_wdata),
    .b_rdata(b_rdata), .b_miss(b_miss)
  );

  // Reference model: plain integers, behaviour from the requirements.
  int ref_mem [544];
  int ref_mode = 0;
  int exp_a = 0, exp_b = 0;
  bit exp_ma = 0, exp_mb = 0;

  function automatic int locate(int mode, bit prog, int addr);
    if (mode == 0) return (!prog && addr < 544) ? addr : -1;
    if (prog) return (addr < 256) ? 288 + addr : -1;
    return (addr < 288) ? addr : -1;
  endfunction

  task automatic check(string tag, string what, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  task automatic drive(bit pa, int aa, bit wa, int da, bit pb, int ab, bit wb, int db);
    a_prog = pa; a_addr = 10'(aa); a_we = wa; a_wdata = 16'(da);
    b_prog = pb; b_addr = 10'(ab); b_we = wb; b_wdata = 16'(db);
  endtask

  // One clock: model the edge, then compare at the following falling edge.
  task automatic step(string tag);
    int ia, ib;
    @(posedge clk);
    ia = locate(ref_mode, a_prog, int'(a_addr));
    ib = locate(ref_mode, b_prog, int'(b_addr));
    exp_ma = (ia < 0); exp_mb = (ib < 0);
    exp_a = (ia < 0) ? 0 : ref_mem[ia];
    exp_b = (ib < 0) ? 0 : ref_mem[ib];
    if (b_we && ib >= 0) ref_mem[ib] = int'(b_wdata);
    if (a_we && ia >= 0) ref_mem[ia] = int'(a_wdata);
    ref_mode = int'(split_mode);
    @(negedge clk);
    check(tag, "a_rdata", int'(a_rdata), exp_a);
    check(tag, "a_miss",  int'(a_miss),  int'(exp_ma));
    check(tag, "b_rdata", int'(b_rdata), exp_b);
    check(tag, "b_miss",  int'(b_miss),  int'(exp_mb));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 544; i++) ref_mem[i] = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "a_rdata", int'(a_rdata), 0);
    check("R1", "a_miss", int'(a_miss), 0);
    check("R1", "b_rdata", int'(b_rdata), 0);
    check("R1", "b_miss", int'(b_miss), 0);
    rst_n = 1'b1;
    drive(0, 0, 0, 0, 0, 1, 0, 0);
    @(negedge clk);
    check("R1", "a_rdata after release", int'(a_rdata), 0);
    // R2 / R7: fill the whole array through both ports in all-data mode
    for (int i = 0; i < 272; i++) begin
      drive(0, 2*i, 1, 16'hA000 ^ (2*i*37), 0, 2*i+1, 1, 16'h5000 ^ ((2*i+1)*91));
      step("R7");
    end
    // R2: boundary reads 0 and 543, 544 misses
    drive(0, 0, 0, 0, 0, 543, 0, 0);       step("R2");
    drive(0, 544, 0, 0, 0, 1023, 0, 0);    step("R2");
    // R3 / R6: program write in all-data mode is dropped; word 293 untouched
    drive(1, 5, 1, 16'hDEAD, 1, 0, 0, 0);  step("R3");
    drive(0, 293, 0, 0, 0, 5, 0, 0);       step("R6");
    // R6: out-of-range data write ignored
    drive(0, 600, 1, 16'hBEEF, 0, 0, 0, 0); step("R6");
    drive(0, 600, 0, 0, 0, 88, 0, 0);      step("R6");
    // R8: same-word double write, A wins
    drive(0, 100, 1, 16'h1111, 0, 100, 1, 16'h2222); step("R8");
    drive(0, 100, 0, 0, 0, 100, 0, 0);     step("R8");
    // R9: read of word being written returns old contents
    drive(0, 200, 1, 16'h3333, 0, 200, 0, 0); step("R9");
    drive(0, 0, 0, 0, 0, 200, 0, 0);       step("R9");
    // R10: switch to split; old mode holds for the edge that samples it
    split_mode = 1'b1;
    drive(1, 0, 0, 0, 0, 300, 0, 0);       step("R10");
    drive(1, 255, 0, 0, 0, 287, 0, 0);     step("R10");
    // R4 / R5 boundaries in split mode
    drive(0, 288, 0, 0, 1, 256, 0, 0);     step("R4");
    drive(1, 0, 1, 16'h7777, 0, 287, 1, 16'h8888); step("R5");
    drive(1, 0, 0, 0, 0, 287, 0, 0);       step("R5");
    // R10: back to all-data, contents kept (word 288 = program 0)
    split_mode = 1'b0;
    drive(0, 288, 0, 0, 0, 287, 0, 0);     step("R10");
    drive(0, 288, 0, 0, 0, 543, 0, 0);     step("R10");
    // R7: pseudo-random mixed traffic with mode flips
    for (int i = 0; i < 400; i++) begin
      int r;
      r = (i * 7919 + 13) ^ (i << 5);
      if (i % 50 == 0) split_mode = ~split_mode;
      drive(r[0], (r >> 1) % 600, r[11], r & 16'hFFFF,
            r[12], (r >> 4) % 600, r[13], (r * 3) & 16'hFFFF);
      step("R7");
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule